// File: doc/BRIEF.md
# Oversampled Serial Receiver with Vote Sampling and Word Queue

This block turns an asynchronous serial line into received words. It runs from the system clock and uses a separate one-cycle strobe that fires sixteen times per bit period. In plain line mode, an idle-high line falls to begin a frame. Each bit is then settled by a two-out-of-three vote near the middle of the bit. In infrared pulse mode, the line idles low and a zero bit arrives as a brief high pulse. Each bit is then read from one sample taken early in the pulse, which filters out very narrow spikes.

Frames carry seven or eight data bits, least significant first. An optional extra bit can follow the data, and one stop bit ends the frame. A frame with a good stop bit lands in an eight-entry queue, or in a single holding register when the queue is switched off. A bad stop bit raises a sticky line-error flag instead. The host sees the oldest word and its extra bit, a not-empty flag and the error flag. It removes words with a pop strobe and can wipe everything with a clear strobe.

Top module: `uart_rx_vote`

## Requirements
- R1: In plain mode a frame starts on a high-to-low step of the synchronised line. If the vote at sample slots 7, 8 and 9 of the first bit finds the line high, the start is dropped and no word is produced.
- R2: In plain mode each bit is the majority of three samples taken at slots 7, 8 and 9 of its sixteen. A disturbance that flips only one of the three samples does not change the bit.
- R3: Data arrives least significant bit first. With `cfg_seven`=1 seven data bits are taken and `rd_data[7]` reads 0. With `cfg_extra`=1 one more bit follows the data and is kept as `rd_ninth`; with `cfg_extra`=0 `rd_ninth` is always 0.
- R4: A stop bit sampled as 0 stores no word and sets `frame_err`. The flag is not changed by `pop`. It clears when the next frame with a good stop bit arrives.
- R5: With `cfg_fifo_on`=1 up to 8 words are held and read oldest first. `not_empty` stays 1 while at least one word is held.
- R6: A word that arrives while 8 words are held empties the whole queue, and that word is dropped as well.
- R7: With `cfg_fifo_on`=0 a single register holds the most recent word, and each new word replaces the one held.
- R8: When nothing is held, `rd_data` and `rd_ninth` read 0. A `pop` then has no effect.
- R9: With `cfg_irda`=1 the line idles low and a rising step starts a frame. Each bit is one sample taken at slot 2 of its sixteen: high means 0 and low means 1. A pulse shorter than one slot starts no frame.
- R10: `clear` empties the store, clears `frame_err` and stops any frame in progress.
- R11: After reset nothing is held, the outputs read 0 and `frame_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx | input | 1 | Serial line, asynchronous to clk |
| tick | input | 1 | One-cycle strobe, sixteen per bit period |
| cfg_seven | input | 1 | 1 selects seven data bits, 0 selects eight |
| cfg_extra | input | 1 | 1 expects an extra bit after the data |
| cfg_fifo_on | input | 1 | 1 uses the eight-entry queue, 0 a single register |
| cfg_irda | input | 1 | 1 selects infrared pulse coding |
| pop | input | 1 | Removes the oldest word |
| clear | input | 1 | Empties the store and clears the error flag |
| rd_data | output | 8 | Oldest held data word, 0 when empty |
| rd_ninth | output | 1 | Extra bit of the oldest word, 0 when empty |
| not_empty | output | 1 | At least one word is held |
| frame_err | output | 1 | Last finished frame had a bad stop bit |

## Verification
The plain-mode receiver gets clean frames in each of the four length and extra-bit combinations, so that a wrong bit count or a misplaced extra bit shows up. It also gets frames with a one-sample spike placed inside the vote window, which separates a true majority vote from a single centre sample. A short low blip tests that a false start is rejected. A frame ending in a low stop bit, placed between good frames, shows that the error flag survives a pop and is cleared by the next good frame. Streams of eight and nine frames separate the full-queue behaviour from the wipe on overflow. Infrared frames together with a spike narrower than one slot show that pulse decoding works and that narrow spikes are filtered out.

// File: rtl/rxv_pkg.sv
package rxv_pkg;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_START,
        RX_BITS,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic       ninth;
        logic [7:0] data;
    } rx_word_t;

    // two-out-of-three majority
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // turn the raw bit vector into a stored word for the current format
    function automatic rx_word_t assemble(input logic [8:0] raw,
                                          input logic seven,
                                          input logic extra);
        rx_word_t w;
        w.data  = seven ? {1'b0, raw[6:0]} : raw[7:0];
        w.ninth = extra ? (seven ? raw[7] : raw[8]) : 1'b0;
        return w;
    endfunction

endpackage

// File: rtl/rxv_sync.sv
module rxv_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_in,
    output logic rx_s,
    output logic rx_rise,
    output logic rx_fall
);
    // STAGES flops of synchroniser plus one for edge history
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], rx_in};
        end
    end

    assign rx_s    = pipe_q[STAGES-1];
    assign rx_rise = rx_s & ~pipe_q[STAGES];
    assign rx_fall = ~rx_s & pipe_q[STAGES];

endmodule

// File: rtl/rxv_frame.sv
module rxv_frame
    import rxv_pkg::*;
#(
    parameter int unsigned OSR       = 16,
    parameter int unsigned IR_SAMPLE = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  logic     tick,
    input  logic     rx_s,
    input  logic     rx_rise,
    input  logic     rx_fall,
    input  logic     cfg_seven,
    input  logic     cfg_extra,
    input  logic     cfg_irda,
    output logic     push,
    output rx_word_t push_word,
    output logic     fe_event
);
    localparam int unsigned CW = $clog2(OSR);
    localparam logic [CW-1:0] CNT_LAST = CW'(OSR - 1);
    localparam logic [CW-1:0] VOTE_A   = CW'(OSR / 2 - 2);
    localparam logic [CW-1:0] VOTE_B   = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] VOTE_C   = CW'(OSR / 2);
    localparam logic [CW-1:0] IR_AT    = CW'(IR_SAMPLE);

    rx_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic [3:0]    bidx_q;
    logic [8:0]    bits_q;
    logic          s_a_q, s_b_q;

    logic          start_edge, decide, bit_val, bit_end;
    logic [3:0]    last_idx;

    assign start_edge = cfg_irda ? rx_rise : rx_fall;
    assign decide     = tick && (state_q != RX_HUNT) &&
                        (cnt_q == (cfg_irda ? IR_AT : VOTE_C));
    assign bit_val    = cfg_irda ? ~rx_s : vote3(s_a_q, s_b_q, rx_s);
    assign bit_end    = tick && (cnt_q == CNT_LAST);
    assign last_idx   = 4'd7 - {3'd0, cfg_seven} + {3'd0, cfg_extra};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state_q   <= RX_HUNT;
            cnt_q     <= '0;
            bidx_q    <= '0;
            bits_q    <= '0;
            s_a_q     <= 1'b1;
            s_b_q     <= 1'b1;
            push      <= 1'b0;
            push_word <= '0;
            fe_event  <= 1'b0;
        end else begin
            push     <= 1'b0;
            fe_event <= 1'b0;
            if (tick && state_q != RX_HUNT) begin
                cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
                if (cnt_q == VOTE_A) s_a_q <= rx_s;
                if (cnt_q == VOTE_B) s_b_q <= rx_s;
            end
            case (state_q)
                RX_HUNT: begin
                    if (start_edge) begin
                        state_q <= RX_START;
                        cnt_q   <= '0;
                    end
                end
                RX_START: begin
                    if (decide && bit_val) begin
                        state_q <= RX_HUNT;
                    end else if (bit_end) begin
                        state_q <= RX_BITS;
                        bidx_q  <= '0;
                    end
                end
                RX_BITS: begin
                    if (decide) bits_q[bidx_q] <= bit_val;
                    if (bit_end) begin
                        bidx_q <= bidx_q + 1'b1;
                        if (bidx_q == last_idx) state_q <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (decide) begin
                        state_q <= RX_HUNT;
                        if (bit_val) begin
                            push      <= 1'b1;
                            push_word <= assemble(bits_q, cfg_seven, cfg_extra);
                        end else begin
                            fe_event  <= 1'b1;
                        end
                    end
                end
                default: state_q <= RX_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/rxv_fifo.sv
module rxv_fifo
    import rxv_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         cfg_fifo_on,
    input  logic                         push,
    input  rx_word_t                     push_word,
    input  logic                         pop,
    output rx_word_t                     head,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned LW = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);

    rx_word_t      mem_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q, wr_addr;
    logic [LW-1:0] level_q;
    logic          has, full, do_pop, wr_en;

    function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign has    = (level_q != '0);
    assign full   = (level_q == LVL_FULL);
    assign do_pop = pop && has;

    always_comb begin
        if (cfg_fifo_on) begin
            wr_en   = push && (!full || do_pop);
            wr_addr = wr_q;
        end else begin
            wr_en   = push;
            wr_addr = rd_q;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_q    <= '0;
            rd_q    <= '0;
            level_q <= '0;
        end else if (cfg_fifo_on) begin
            if (push && full && !do_pop) begin
                wr_q    <= '0;
                rd_q    <= '0;
                level_q <= '0;
            end else begin
                if (push)   wr_q <= inc(wr_q);
                if (do_pop) rd_q <= inc(rd_q);
                if (push && !do_pop)      level_q <= level_q + 1'b1;
                else if (!push && do_pop) level_q <= level_q - 1'b1;
            end
        end else begin
            if (push)        level_q <= LW'(1);
            else if (do_pop) level_q <= '0;
        end
    end

    assign head  = has ? mem_q[rd_q] : '0;
    assign level = level_q;

endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote
    import rxv_pkg::*;
#(
    parameter int unsigned DEPTH       = 8,
    parameter int unsigned OSR         = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned IR_SAMPLE   = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx,
    input  logic       tick,
    input  logic       cfg_seven,
    input  logic       cfg_extra,
    input  logic       cfg_fifo_on,
    input  logic       cfg_irda,
    input  logic       pop,
    input  logic       clear,
    output logic [7:0] rd_data,
    output logic       rd_ninth,
    output logic       not_empty,
    output logic       frame_err
);
    localparam int unsigned LW = $clog2(DEPTH + 1);

    logic          rx_s, rx_rise, rx_fall;
    logic          push, fe_event;
    rx_word_t      push_word, head;
    logic [LW-1:0] fill_level;

    rxv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .rx_in   (rx),
        .rx_s    (rx_s),
        .rx_rise (rx_rise),
        .rx_fall (rx_fall)
    );

    rxv_frame #(.OSR(OSR), .IR_SAMPLE(IR_SAMPLE)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .tick      (tick),
        .rx_s      (rx_s),
        .rx_rise   (rx_rise),
        .rx_fall   (rx_fall),
        .cfg_seven (cfg_seven),
        .cfg_extra (cfg_extra),
        .cfg_irda  (cfg_irda),
        .push      (push),
        .push_word (push_word),
        .fe_event  (fe_event)
    );

    rxv_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk         (clk),
        .rst         (rst),
        .clear       (clear),
        .cfg_fifo_on (cfg_fifo_on),
        .push        (push),
        .push_word   (push_word),
        .pop         (pop),
        .head        (head),
        .level       (fill_level)
    );

    // sticky line-error flag: set by a bad stop, cleared by a good frame
    always_ff @(posedge clk) begin
        if (rst || clear)  frame_err <= 1'b0;
        else if (fe_event) frame_err <= 1'b1;
        else if (push)     frame_err <= 1'b0;
    end

    assign rd_data   = head.data;
    assign rd_ninth  = head.ninth;
    assign not_empty = (fill_level != '0);

endmodule

// File: rtl/rxv_checker.sv
module rxv_checker
    import rxv_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       clear,
    input logic                       pop,
    input logic                       cfg_fifo_on,
    input logic                       cfg_extra,
    input logic                       not_empty,
    input logic [7:0]                 rd_data,
    input logic                       rd_ninth,
    input logic                       frame_err,
    input logic                       push,
    input rx_word_t                   push_word,
    input logic                       fe_event,
    input logic [$clog2(DEPTH+1)-1:0] fill_level
);
    localparam int unsigned LW = $clog2(DEPTH + 1);

    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !not_empty |-> (rd_data == 8'h00 && !rd_ninth));                            // R8
    AST_POP_EMPTY_NOP: assert property (@(posedge clk) disable iff (rst)
        (!not_empty && pop && !push && !clear) |=> !not_empty);                    // R8
    AST_NINTH_OFF: assert property (@(posedge clk) disable iff (rst)
        (push && !cfg_extra) |-> !push_word.ninth);                                // R3
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!not_empty && !frame_err));                                     // R10
    AST_WIPE_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        (cfg_fifo_on && fill_level == LW'(DEPTH) && push && !pop && !clear)
        |=> (fill_level == '0));                                                   // R6
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill_level <= LW'(DEPTH));                                                 // R5
    AST_BYPASS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (!cfg_fifo_on && push && !clear) |=> (fill_level == LW'(1)));              // R7
    AST_FE_SETS: assert property (@(posedge clk) disable iff (rst)
        (fe_event && !clear) |=> frame_err);                                       // R4
    AST_GOOD_CLEARS_FE: assert property (@(posedge clk) disable iff (rst)
        (push && !clear) |=> !frame_err);                                          // R4

endmodule

bind uart_rx_vote rxv_checker #(.DEPTH(DEPTH)) i_chk (.*);

// File: tb/test_uart_rx_vote.sv
module test_uart_rx_vote;

    localparam int TICK_DIV = 8;
    localparam int BIT_CLK  = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic       cfg_seven = 1'b0, cfg_extra = 1'b0, cfg_fifo_on = 1'b1, cfg_irda = 1'b0;
    logic       pop = 1'b0, clear = 1'b0;
    logic [7:0] rd_data;
    logic       rd_ninth, not_empty, frame_err;

    int n_chk = 0;
    int n_bad = 0;

    uart_rx_vote i_uart_rx_vote (
        .clk(clk), .rst(rst), .rx(rx), .tick(tick),
        .cfg_seven(cfg_seven), .cfg_extra(cfg_extra),
        .cfg_fifo_on(cfg_fifo_on), .cfg_irda(cfg_irda),
        .pop(pop), .clear(clear),
        .rd_data(rd_data), .rd_ninth(rd_ninth),
        .not_empty(not_empty), .frame_err(frame_err)
    );

    always #10 clk = ~clk;

    int tick_cnt = 0;
    always @(negedge clk) begin
        tick_cnt = (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
        tick <= (tick_cnt == 0);
    end

    task automatic hold(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_pop();
        pop = 1'b1;
        hold(1);
        pop = 1'b0;
        hold(1);
    endtask

    task automatic do_clear();
        clear = 1'b1;
        hold(1);
        clear = 1'b0;
        hold(1);
    endtask

    // plain-mode bit, optionally with an 8-cycle spike around the centre
    task automatic nrz_bit(input logic v, input logic spike);
        rx = v;
        if (spike) begin
            hold(60); rx = ~v; hold(8); rx = v; hold(60);
        end else begin
            hold(BIT_CLK);
        end
    endtask

    task automatic send_nrz(input logic [8:0] bits, input int n, input logic stop_v,
                            input int spike_at);
        nrz_bit(1'b0, 1'b0);
        for (int i = 0; i < n; i++) nrz_bit(bits[i], i == spike_at);
        nrz_bit(stop_v, 1'b0);
        rx = 1'b1;
        hold(32);
    endtask

    task automatic ir_bit(input logic v);
        if (!v) begin
            rx = 1'b1; hold(24); rx = 1'b0; hold(BIT_CLK - 24);
        end else begin
            rx = 1'b0; hold(BIT_CLK);
        end
    endtask

    task automatic send_ir(input logic [8:0] bits, input int n);
        ir_bit(1'b0);
        for (int i = 0; i < n; i++) ir_bit(bits[i]);
        ir_bit(1'b1);
        hold(32);
    endtask

    task automatic expect_head(input string tag, input logic [7:0] d, input logic nb);
        chk({tag, " not_empty"}, {15'd0, not_empty}, 16'd1);
        chk({tag, " data"}, {8'd0, rd_data}, {8'd0, d});
        chk({tag, " ninth"}, {15'd0, rd_ninth}, {15'd0, nb});
        do_pop();
    endtask

    task automatic t_reset();
        chk("R11 not_empty", {15'd0, not_empty}, 16'd0);
        chk("R11 data", {8'd0, rd_data}, 16'd0);
        chk("R11 ninth", {15'd0, rd_ninth}, 16'd0);
        chk("R11 frame_err", {15'd0, frame_err}, 16'd0);
    endtask

    task automatic t_formats();
        cfg_seven = 1'b0; cfg_extra = 1'b0; hold(2);
        send_nrz(9'h0A5, 8, 1'b1, -1);
        expect_head("R3 8b", 8'hA5, 1'b0);
        cfg_seven = 1'b1; cfg_extra = 1'b0; hold(2);
        send_nrz(9'h07F, 7, 1'b1, -1);
        expect_head("R3 7b msb0", 8'h7F, 1'b0);
        cfg_seven = 1'b1; cfg_extra = 1'b1; hold(2);
        send_nrz(9'h0AA, 8, 1'b1, -1);
        expect_head("R3 7b+x", 8'h2A, 1'b1);
        cfg_seven = 1'b0; cfg_extra = 1'b1; hold(2);
        send_nrz(9'h1C3, 9, 1'b1, -1);
        expect_head("R3 8b+x", 8'hC3, 1'b1);
        cfg_seven = 1'b0; cfg_extra = 1'b0; hold(2);
    endtask

    task automatic t_vote();
        send_nrz(9'h000, 8, 1'b1, 3);
        expect_head("R2 spike in 0", 8'h00, 1'b0);
        send_nrz(9'h0FF, 8, 1'b1, 5);
        expect_head("R2 spike in 1", 8'hFF, 1'b0);
    endtask

    task automatic t_false_start();
        rx = 1'b0; hold(24); rx = 1'b1; hold(300);
        chk("R1 blip no word", {15'd0, not_empty}, 16'd0);
        chk("R1 blip no error", {15'd0, frame_err}, 16'd0);
        send_nrz(9'h042, 8, 1'b1, -1);
        expect_head("R1 start after blip", 8'h42, 1'b0);
    endtask

    task automatic t_frame_err();
        send_nrz(9'h011, 8, 1'b1, -1);
        send_nrz(9'h055, 8, 1'b0, -1);
        chk("R4 error set", {15'd0, frame_err}, 16'd1);
        expect_head("R4 bad frame not stored", 8'h11, 1'b0);
        chk("R4 error kept after pop", {15'd0, frame_err}, 16'd1);
        chk("R4 nothing left", {15'd0, not_empty}, 16'd0);
        send_nrz(9'h022, 8, 1'b1, -1);
        chk("R4 good frame clears", {15'd0, frame_err}, 16'd0);
        expect_head("R4 next word", 8'h22, 1'b0);
    endtask

    task automatic t_order();
        for (int i = 0; i < 8; i++) send_nrz(9'(16 + i), 8, 1'b1, -1);
        for (int i = 0; i < 8; i++) expect_head("R5 order", 8'(16 + i), 1'b0);
        chk("R5 drained", {15'd0, not_empty}, 16'd0);
        chk("R8 empty data", {8'd0, rd_data}, 16'd0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 9; i++) send_nrz(9'(32 + i), 8, 1'b1, -1);
        chk("R6 wiped", {15'd0, not_empty}, 16'd0);
        chk("R6 wiped data", {8'd0, rd_data}, 16'd0);
        send_nrz(9'h077, 8, 1'b1, -1);
        expect_head("R6 after wipe", 8'h77, 1'b0);
        chk("R6 single word", {15'd0, not_empty}, 16'd0);
    endtask

    task automatic t_bypass();
        cfg_fifo_on = 1'b0; hold(2);
        send_nrz(9'h031, 8, 1'b1, -1);
        send_nrz(9'h032, 8, 1'b1, -1);
        expect_head("R7 newest kept", 8'h32, 1'b0);
        chk("R7 one slot", {15'd0, not_empty}, 16'd0);
        cfg_fifo_on = 1'b1; hold(2);
    endtask

    task automatic t_pop_empty();
        do_pop();
        chk("R8 pop empty flag", {15'd0, not_empty}, 16'd0);
        chk("R8 pop empty data", {7'd0, rd_ninth, rd_data}, 16'd0);
    endtask

    task automatic t_clear();
        send_nrz(9'h066, 8, 1'b1, -1);
        send_nrz(9'h099, 8, 1'b0, -1);
        chk("R10 before clear", {14'd0, not_empty, frame_err}, 16'd3);
        do_clear();
        chk("R10 after clear", {14'd0, not_empty, frame_err}, 16'd0);
    endtask

    task automatic t_irda();
        cfg_irda = 1'b1; hold(2);
        rx = 1'b0; hold(40);
        do_clear();
        send_ir(9'h096, 8);
        expect_head("R9 pulse frame", 8'h96, 1'b0);
        rx = 1'b1; hold(4); rx = 1'b0; hold(400);
        chk("R9 narrow pulse ignored", {15'd0, not_empty}, 16'd0);
        send_ir(9'h03C, 8);
        expect_head("R9 after narrow pulse", 8'h3C, 1'b0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        hold(4);
        rst = 1'b0;
        hold(40);
        t_reset();
        t_formats();
        t_vote();
        t_false_start();
        t_frame_err();
        t_order();
        t_overflow();
        t_bypass();
        t_pop_empty();
        t_clear();
        t_irda();
        finish_run();
    end

endmodule